// File: doc/BRIEF.md
# Reserved-Address Control Frame Trap Classifier

This block makes the forwarding decision at ingress for a small Ethernet switch that has one management (CPU) port. For each received frame it is given the destination MAC address, the EtherType, a VLAN-tagged flag, a PVID-valid flag for the ingress port, a flag telling whether that port's spanning-tree state is discarding, and the port mask and egress tag mode that the normal address lookup produced. It decides which ports get the frame, which egress tag mode applies and whether the frame is dropped.

Frames sent to the reserved group range 01-80-C2-00-00-xx, and port-authentication frames identified by EtherType, are sorted into trap classes. Each class has its own rule in a software-written control register: a forward mode, an egress tag mode and a flag that lets the frame pass a port whose spanning-tree state is discarding. The flag does not lift the check that drops untagged frames on a port with no PVID. One catch-all class covers the remaining reserved codes and, by design, also the upper part of the range (0x22 to 0xFF). The decision is registered and appears one clock after the frame strobe. Frames may arrive on consecutive cycles.

Top module: `ctl_frame_trap`

## Requirements
- R1: With the prefix 01-80-C2-00-00 in address bits 47:8, the last byte selects a dedicated class: 0x00 spanning-tree class, 0x01, 0x02, 0x03 and 0x0E each their own class.
- R2: The catch-all class matches last bytes 0x04 to 0x0D, 0x0F and 0x22 to 0xFF under the same prefix, and never 0x10 to 0x21.
- R3: EtherType 0x888E selects the port-authentication class whatever the destination address, and this class wins over every address class, including 0x03.
- R4: Registers reset to 0 and read back only their defined bits. Each rule word holds two classes: the upper class has its stp-bypass flag at bit 25, egress tag at bits 24:22 and forward mode at bits 18:16; the lower class uses bits 9, 8:6 and 2:0. Word 0x24 holds spanning-tree (lower) and port-authentication (upper), 0x28 holds 0x01 (lower) and 0x02 (upper), 0x2C holds 0x03 (lower) and 0x0E (upper), 0x34 holds the catch-all (lower only). The CPU port index sits at 0x30 bits 2:0.
- R5: Forward mode of a matched class: 0 keeps the lookup mask, 4 sends to the CPU port only, 5 removes the CPU port from the lookup mask, 6 adds the CPU port to it, 7 drops; 1, 2 and 3 act as 0. An unmatched frame keeps the lookup mask.
- R6: Egress tag out: mode 4 forces 0 (untagged); modes 5 and 6 give the class's egress tag field; all other cases give the lookup tag mode.
- R7: When the ingress port is discarding, the frame is dropped unless it matched a class whose stp-bypass flag is set.
- R8: An untagged frame on a port with no valid PVID is dropped even when it matched a class with the stp-bypass flag set.
- R9: A dropped frame has an all-zero port mask and tag mode 0.
- R10: The decision for a frame presented with the valid strobe appears with the output valid exactly one clock later; back-to-back frames give back-to-back decisions, and no strobe gives output valid low.
- R11: A frame outside the reserved prefix and without EtherType 0x888E passes the lookup mask and tag unchanged unless dropped by R7 or R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| frmValid | input | 1 | Frame descriptor valid strobe |
| frmDstMac | input | 48 | Destination MAC address |
| frmEthType | input | 16 | EtherType |
| frmTagged | input | 1 | Frame carries a VLAN tag |
| frmPvidValid | input | 1 | Ingress port has a valid PVID |
| frmStpDiscard | input | 1 | Ingress port spanning-tree state is discarding |
| frmLookupMask | input | 7 | Port mask from the normal lookup |
| frmLookupTag | input | 3 | Egress tag mode from the normal lookup |
| outValid | output | 1 | Decision valid |
| outMask | output | 7 | Destination port mask |
| outTag | output | 3 | Egress tag mode |
| outDrop | output | 1 | Frame dropped |

## Verification
A wrong class selection or a corrupted rule word shows up in the very next decision after the affected frame, as an unexpected egress tag or a missing or extra CPU bit in the mask; giving every class a distinct tag field makes the chosen class visible on outTag alone, so a full sweep of the last address byte exposes any decode error in one cycle per code. A broken bypass or PVID path shows as a wrong outDrop on the one frame that combines discarding or untagged state with a matching class. Register bit slips show at once in read-back and in the decision for the class concerned.

// File: rtl/ctl_trap_pkg.sv
package ctl_trap_pkg;

  localparam int NUM_CLASS  = 8;
  localparam int MODE_W     = 3;
  localparam int HALF_SHIFT = 16;

  typedef enum logic [2:0] {
    CLS_STP  = 3'd0,
    CLS_PAE  = 3'd1,
    CLS_R01  = 3'd2,
    CLS_R02  = 3'd3,
    CLS_R03  = 3'd4,
    CLS_R0E  = 3'd5,
    CLS_UNK  = 3'd6,
    CLS_NONE = 3'd7
  } trapClass_e;

  typedef struct packed {
    logic              bypass;
    logic [MODE_W-1:0] tag;
    logic [MODE_W-1:0] fwd;
  } classCfg_t;

  // strobes from the classifier to the decision datapath
  typedef struct packed {
    logic              hit;
    logic              bypassStp;
    logic [MODE_W-1:0] fwdMode;
    logic [MODE_W-1:0] tagMode;
  } trapCtl_t;

  localparam logic [MODE_W-1:0] FWD_CPU_ONLY = 3'd4;
  localparam logic [MODE_W-1:0] FWD_NO_CPU   = 3'd5;
  localparam logic [MODE_W-1:0] FWD_ADD_CPU  = 3'd6;
  localparam logic [MODE_W-1:0] FWD_DROP     = 3'd7;
  localparam logic [MODE_W-1:0] TAG_UNTAGGED = 3'd0;

  localparam logic [39:0] RSV_PREFIX   = 40'h0180C20000;
  localparam logic [15:0] PAE_ETHTYPE  = 16'h888E;

  localparam int REG_RULE_BASE = 'h24;
  localparam int REG_CPU       = 'h30;
  localparam int REG_UNK       = 'h34;

  function automatic logic [31:0] packPair(classCfg_t lo, classCfg_t hi);
    logic [31:0] w;
    w        = '0;
    w[9]     = lo.bypass;
    w[8:6]   = lo.tag;
    w[2:0]   = lo.fwd;
    w[25]    = hi.bypass;
    w[24:22] = hi.tag;
    w[18:16] = hi.fwd;
    return w;
  endfunction

endpackage

// File: rtl/ctl_trap_regs.sv
module ctl_trap_regs
  import ctl_trap_pkg::*;
#(
  parameter int AddrW    = 8,
  parameter int DataW    = 32,
  parameter int PortIdxW = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWrEn,
  input  logic [AddrW-1:0]                 regAddr,
  input  logic [DataW-1:0]                 regWrData,
  output logic [DataW-1:0]                 regRdData,
  output classCfg_t [NUM_CLASS-1:0]        cfgVec,
  output logic [PortIdxW-1:0]              cpuIdx
);

  localparam int NumPair = NUM_CLASS / 2;

  function automatic logic [AddrW-1:0] pairAddr(int p);
    return (p < NumPair - 1) ? AddrW'(REG_RULE_BASE + 4 * p) : AddrW'(REG_UNK);
  endfunction

  // one rule per class; the class index picks the word and the half
  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
    if (c == int'(CLS_NONE)) begin : g_empty
      assign cfgVec[c] = '0;
    end else begin : g_rule
      localparam int Base = (c % 2) * HALF_SHIFT;
      classCfg_t ruleQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          ruleQ <= '0;
        end else if (regWrEn && regAddr == pairAddr(c / 2)) begin
          ruleQ <= {regWrData[Base+9], regWrData[Base+8 -: 3], regWrData[Base+2 -: 3]};
        end
      end
      assign cfgVec[c] = ruleQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuIdx <= '0;
    end else if (regWrEn && regAddr == AddrW'(REG_CPU)) begin
      cpuIdx <= regWrData[PortIdxW-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    for (int p = 0; p < NumPair; p++) begin
      if (regAddr == pairAddr(p)) begin
        regRdData = DataW'(packPair(cfgVec[2*p], cfgVec[2*p+1]));
      end
    end
    if (regAddr == AddrW'(REG_CPU)) begin
      regRdData = DataW'(cpuIdx);
    end
  end

  logic unusedWrBits;
  assign unusedWrBits = ^{regWrData[DataW-1:26], regWrData[21:19],
                          regWrData[15:10], regWrData[5:3]};

endmodule

// File: rtl/ctl_trap_match.sv
module ctl_trap_match
  import ctl_trap_pkg::*;
(
  input  logic [47:0]               dstMac,
  input  logic [15:0]               ethType,
  input  classCfg_t [NUM_CLASS-1:0] cfgVec,
  output trapClass_e                matchCls,
  output trapCtl_t                  trapCtl
);

  logic [7:0] lastByte;
  logic       inPrefix;
  logic       unkCode;
  classCfg_t  selCfg;

  assign lastByte = dstMac[7:0];
  assign inPrefix = (dstMac[47:8] == RSV_PREFIX);
  assign unkCode  = (lastByte >= 8'h04 && lastByte <= 8'h0D) ||
                    (lastByte == 8'h0F) || (lastByte >= 8'h22);

  // authentication EtherType first, then the address classes
  always_comb begin
    matchCls = CLS_NONE;
    if (ethType == PAE_ETHTYPE) begin
      matchCls = CLS_PAE;
    end else if (inPrefix) begin
      unique case (lastByte)
        8'h00:   matchCls = CLS_STP;
        8'h01:   matchCls = CLS_R01;
        8'h02:   matchCls = CLS_R02;
        8'h03:   matchCls = CLS_R03;
        8'h0E:   matchCls = CLS_R0E;
        default: matchCls = unkCode ? CLS_UNK : CLS_NONE;
      endcase
    end
  end

  assign selCfg            = cfgVec[matchCls];
  assign trapCtl.hit       = (matchCls != CLS_NONE);
  assign trapCtl.bypassStp = trapCtl.hit && selCfg.bypass;
  assign trapCtl.fwdMode   = trapCtl.hit ? selCfg.fwd : '0;
  assign trapCtl.tagMode   = selCfg.tag;

endmodule

// File: rtl/ctl_trap_path.sv
module ctl_trap_path
  import ctl_trap_pkg::*;
#(
  parameter int NumPorts = 7,
  parameter int PortIdxW = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frmValid,
  input  logic                frmTagged,
  input  logic                frmPvidValid,
  input  logic                frmStpDiscard,
  input  logic [NumPorts-1:0] frmLookupMask,
  input  logic [MODE_W-1:0]   frmLookupTag,
  input  logic [PortIdxW-1:0] cpuIdx,
  input  trapCtl_t            trapCtl,
  output logic                outValid,
  output logic [NumPorts-1:0] outMask,
  output logic [MODE_W-1:0]   outTag,
  output logic                outDrop
);

  logic [NumPorts-1:0] cpuBit;
  logic [NumPorts-1:0] nxtMask;
  logic [MODE_W-1:0]   nxtTag;
  logic                nxtDrop;
  logic                modeDrop;

  assign cpuBit = (int'(cpuIdx) < NumPorts) ?
                  ({{(NumPorts-1){1'b0}}, 1'b1} << cpuIdx) : '0;

  always_comb begin
    modeDrop = 1'b0;
    nxtMask  = frmLookupMask;
    nxtTag   = frmLookupTag;
    case (trapCtl.fwdMode)
      FWD_CPU_ONLY: begin
        nxtMask = cpuBit;
        nxtTag  = TAG_UNTAGGED;
      end
      FWD_NO_CPU: begin
        nxtMask = frmLookupMask & ~cpuBit;
        nxtTag  = trapCtl.tagMode;
      end
      FWD_ADD_CPU: begin
        nxtMask = frmLookupMask | cpuBit;
        nxtTag  = trapCtl.tagMode;
      end
      FWD_DROP: modeDrop = 1'b1;
      default: ;
    endcase
    nxtDrop = modeDrop || (frmStpDiscard && !trapCtl.bypassStp) ||
              (!frmTagged && !frmPvidValid);
    if (nxtDrop) begin
      nxtMask = '0;
      nxtTag  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outMask  <= '0;
      outTag   <= '0;
      outDrop  <= 1'b0;
    end else begin
      outValid <= frmValid;
      if (frmValid) begin
        outMask <= nxtMask;
        outTag  <= nxtTag;
        outDrop <= nxtDrop;
      end
    end
  end

endmodule

// File: rtl/ctl_frame_trap.sv
module ctl_frame_trap
  import ctl_trap_pkg::*;
#(
  parameter int NumPorts = 7,
  parameter int AddrW    = 8,
  parameter int DataW    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [AddrW-1:0]    regAddr,
  input  logic [DataW-1:0]    regWrData,
  output logic [DataW-1:0]    regRdData,
  input  logic                frmValid,
  input  logic [47:0]         frmDstMac,
  input  logic [15:0]         frmEthType,
  input  logic                frmTagged,
  input  logic                frmPvidValid,
  input  logic                frmStpDiscard,
  input  logic [NumPorts-1:0] frmLookupMask,
  input  logic [2:0]          frmLookupTag,
  output logic                outValid,
  output logic [NumPorts-1:0] outMask,
  output logic [2:0]          outTag,
  output logic                outDrop
);

  localparam int PortIdxW = $clog2(NumPorts);

  classCfg_t [NUM_CLASS-1:0] cfgVec;
  logic [PortIdxW-1:0]       cpuIdx;
  trapClass_e                matchCls;
  trapCtl_t                  trapCtl;

  ctl_trap_regs #(.AddrW(AddrW), .DataW(DataW), .PortIdxW(PortIdxW)) regs_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cfgVec    (cfgVec),
    .cpuIdx    (cpuIdx)
  );

  ctl_trap_match match_i (
    .dstMac   (frmDstMac),
    .ethType  (frmEthType),
    .cfgVec   (cfgVec),
    .matchCls (matchCls),
    .trapCtl  (trapCtl)
  );

  ctl_trap_path #(.NumPorts(NumPorts), .PortIdxW(PortIdxW)) path_i (
    .clk           (clk),
    .rstN          (rstN),
    .frmValid      (frmValid),
    .frmTagged     (frmTagged),
    .frmPvidValid  (frmPvidValid),
    .frmStpDiscard (frmStpDiscard),
    .frmLookupMask (frmLookupMask),
    .frmLookupTag  (frmLookupTag),
    .cpuIdx        (cpuIdx),
    .trapCtl       (trapCtl),
    .outValid      (outValid),
    .outMask       (outMask),
    .outTag        (outTag),
    .outDrop       (outDrop)
  );

  logic unusedCls;
  assign unusedCls = ^matchCls;

endmodule

// File: rtl/ctl_frame_trap_chk.sv
module ctl_frame_trap_chk #(
  parameter int NumPorts = 7
) (
  input logic                clk,
  input logic                rstN,
  input logic                frmValid,
  input logic [47:0]         frmDstMac,
  input logic [15:0]         frmEthType,
  input logic                frmTagged,
  input logic                frmPvidValid,
  input logic                frmStpDiscard,
  input logic [NumPorts-1:0] frmLookupMask,
  input logic [2:0]          frmLookupTag,
  input logic                outValid,
  input logic [NumPorts-1:0] outMask,
  input logic [2:0]          outTag,
  input logic                outDrop,
  input logic                trapHit,
  input logic                trapBypass,
  input logic [2:0]          trapFwd
);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |=> outValid);

  a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !frmValid |=> !outValid);

  a_r9_drop_empty: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outDrop) |-> (outMask == '0 && outTag == 3'd0));

  a_r8_no_pvid_drop: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !frmTagged && !frmPvidValid) |=> outDrop);

  a_r7_discard_drop: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmStpDiscard && !trapBypass) |=> outDrop);

  a_r5_cpu_only_single: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && trapHit && trapFwd == 3'd4) |=> $onehot0(outMask));

  a_r11_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmDstMac[47:8] != 40'h0180C20000 && frmEthType != 16'h888E &&
     !frmStpDiscard && (frmTagged || frmPvidValid))
    |=> (!outDrop && outMask == $past(frmLookupMask) && outTag == $past(frmLookupTag)));

endmodule

bind ctl_frame_trap ctl_frame_trap_chk #(.NumPorts(NumPorts)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .frmValid      (frmValid),
  .frmDstMac     (frmDstMac),
  .frmEthType    (frmEthType),
  .frmTagged     (frmTagged),
  .frmPvidValid  (frmPvidValid),
  .frmStpDiscard (frmStpDiscard),
  .frmLookupMask (frmLookupMask),
  .frmLookupTag  (frmLookupTag),
  .outValid      (outValid),
  .outMask       (outMask),
  .outTag        (outTag),
  .outDrop       (outDrop),
  .trapHit       (trapCtl.hit),
  .trapBypass    (trapCtl.bypassStp),
  .trapFwd       (trapCtl.fwdMode)
);

// File: tb/ctl_frame_trap_tb_top.sv
module ctl_frame_trap_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        frmValid = 1'b0;
  logic [47:0] frmDstMac = '0;
  logic [15:0] frmEthType = '0;
  logic        frmTagged = 1'b1;
  logic        frmPvidValid = 1'b1;
  logic        frmStpDiscard = 1'b0;
  logic [6:0]  frmLookupMask = '0;
  logic [2:0]  frmLookupTag = '0;
  logic        outValid;
  logic [6:0]  outMask;
  logic [2:0]  outTag;
  logic        outDrop;

  int vecCnt = 0;
  int failCnt = 0;

  logic [2:0]  shFwd [7];
  logic [2:0]  shTag [7];
  logic        shByp [7];
  logic [2:0]  shCpu;

  always #2 clk = ~clk;

  ctl_frame_trap dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .frmValid(frmValid),
    .frmDstMac(frmDstMac), .frmEthType(frmEthType), .frmTagged(frmTagged),
    .frmPvidValid(frmPvidValid), .frmStpDiscard(frmStpDiscard),
    .frmLookupMask(frmLookupMask), .frmLookupTag(frmLookupTag),
    .outValid(outValid), .outMask(outMask), .outTag(outTag), .outDrop(outDrop)
  );

  function automatic int expClass(logic [47:0] mac, logic [15:0] et);
    logic [7:0] b = mac[7:0];
    if (et == 16'h888E) return 1;
    if (mac[47:8] != 40'h0180C20000) return 7;
    if (b == 8'h00) return 0;
    if (b == 8'h01) return 2;
    if (b == 8'h02) return 3;
    if (b == 8'h03) return 4;
    if (b == 8'h0E) return 5;
    if ((b >= 8'h04 && b <= 8'h0D) || b == 8'h0F || b >= 8'h22) return 6;
    return 7;
  endfunction

  // {drop, mask, tag}
  function automatic logic [10:0] expOut(int cls, logic [6:0] lm, logic [2:0] lt,
                                         logic tg, logic pv, logic st);
    logic [6:0] cpuBit = (shCpu < 3'd7) ? (7'd1 << shCpu) : 7'd0;
    logic [2:0] f  = (cls < 7) ? shFwd[cls] : 3'd0;
    logic [2:0] tc = (cls < 7) ? shTag[cls] : 3'd0;
    logic       by = (cls < 7) ? shByp[cls] : 1'b0;
    logic       d;
    logic [6:0] m;
    logic [2:0] t;
    d = (f == 3'd7) || (st && !by) || (!tg && !pv);
    case (f)
      3'd4: begin m = cpuBit; t = 3'd0; end
      3'd5: begin m = lm & ~cpuBit; t = tc; end
      3'd6: begin m = lm | cpuBit; t = tc; end
      default: begin m = lm; t = lt; end
    endcase
    if (d) begin m = '0; t = '0; end
    return {d, m, t};
  endfunction

  task automatic note(string req, logic [31:0] act, logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    frmValid  = 1'b0;
    regAddr   = a;
    regWrData = d;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(string req, logic [7:0] a, logic [31:0] exp);
    regAddr = a;
    #1;
    note(req, regRdData, exp);
  endtask

  function automatic logic [7:0] ruleAddr(int c);
    return (c / 2 < 3) ? 8'(8'h24 + 4 * (c / 2)) : 8'h34;
  endfunction

  function automatic logic [31:0] ruleWord(int c);
    logic [31:0] w = '0;
    int lo = c & ~1;
    for (int h = 0; h < 2; h++) begin
      int k = lo + h;
      if (k < 7) begin
        w[16*h + 9]      = shByp[k];
        w[16*h + 6 +: 3] = shTag[k];
        w[16*h +: 3]     = shFwd[k];
      end
    end
    return w;
  endfunction

  task automatic setClass(int c, logic [2:0] f, logic [2:0] t, logic b);
    shFwd[c] = f; shTag[c] = t; shByp[c] = b;
    writeReg(ruleAddr(c), ruleWord(c));
    readCheck("R4 rule readback", ruleAddr(c), ruleWord(c));
  endtask

  task automatic setCpu(logic [2:0] k);
    shCpu = k;
    writeReg(8'h30, {29'h1ABCDEF0, k});
    readCheck("R4 cpu readback", 8'h30, {29'd0, k});
  endtask

  task automatic sendCheck(string req, logic [47:0] mac, logic [15:0] et,
                           logic tg, logic pv, logic st, logic [6:0] lm, logic [2:0] lt);
    logic [10:0] e;
    @(negedge clk);
    frmValid = 1'b1; frmDstMac = mac; frmEthType = et; frmTagged = tg;
    frmPvidValid = pv; frmStpDiscard = st; frmLookupMask = lm; frmLookupTag = lt;
    e = expOut(expClass(mac, et), lm, lt, tg, pv, st);
    @(negedge clk);
    note(req, {20'd0, outValid, outDrop, outMask, outTag}, {20'd0, 1'b1, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    for (int c = 0; c < 7; c++) begin shFwd[c] = 0; shTag[c] = 0; shByp[c] = 0; end
    shCpu = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 / R4 reset state
    note("R10 reset outputs", {28'd0, outValid, outDrop, outMask == 7'd0, outTag == 3'd0},
         {28'd0, 1'b0, 1'b0, 1'b1, 1'b1});
    readCheck("R4 reset 0x24", 8'h24, 32'd0);
    readCheck("R4 reset 0x28", 8'h28, 32'd0);
    readCheck("R4 reset 0x2C", 8'h2C, 32'd0);
    readCheck("R4 reset 0x30", 8'h30, 32'd0);
    readCheck("R4 reset 0x34", 8'h34, 32'd0);

    // R4 reserved bits masked, unused upper half of 0x34
    writeReg(8'h28, 32'hFFFFFFFF);
    readCheck("R4 masked 0x28", 8'h28, 32'h03C703C7);
    writeReg(8'h34, 32'hFFFFFFFF);
    readCheck("R4 masked 0x34", 8'h34, 32'h000003C7);

    // class visible on outTag: mode 6, class c tag c+1
    setCpu(3'd6);
    for (int c = 0; c < 7; c++) setClass(c, 3'd6, 3'(c + 1), 1'b0);
    for (int b = 0; b < 256; b++) begin
      sendCheck((b <= 3 || b == 14) ? "R1 dedicated class" : "R2 catch-all range",
                {40'h0180C20000, 8'(b)}, 16'h0800, 1, 1, 0, 7'h05, 3'd0);
    end
    // R3 EtherType class beats address classes
    sendCheck("R3 pae over 03", 48'h0180C2000003, 16'h888E, 1, 1, 0, 7'h05, 3'd0);
    sendCheck("R3 pae over 00", 48'h0180C2000000, 16'h888E, 1, 1, 0, 7'h05, 3'd0);
    sendCheck("R3 pae plain da", 48'h00112233AABB, 16'h888E, 1, 1, 0, 7'h11, 3'd3);
    // R11 outside the prefix
    for (int b = 0; b < 256; b++) begin
      sendCheck("R11 passthrough", {40'h0180C20001, 8'(b)}, 16'h0800, 1, 1, 0,
                7'(b * 37), 3'(b));
    end

    // R5 / R6 / R9 forward modes over cpu index and masks
    for (int f = 0; f < 8; f++) begin
      setClass(2, 3'(f), 3'd5, 1'b0);
      for (int k = 0; k < 7; k++) begin
        setCpu(3'(k));
        sendCheck("R5 fwd mode mask", 48'h0180C2000001, 16'h0800, 1, 1, 0, 7'h7F, 3'd2);
        sendCheck("R6 fwd mode tag", 48'h0180C2000001, 16'h0800, 1, 1, 0, 7'h2A, 3'd3);
        sendCheck("R9 fwd mode drop", 48'h0180C2000001, 16'h0800, 1, 1, 0, 7'h15, 3'd7);
        sendCheck("R5 empty lookup", 48'h0180C2000001, 16'h0800, 1, 1, 0, 7'h00, 3'd1);
      end
    end

    // R7 / R8 state combinations
    setCpu(3'd0);
    for (int by = 0; by < 2; by++) begin
      setClass(0, 3'd4, 3'd2, 1'(by));
      for (int s = 0; s < 8; s++) begin
        sendCheck(s[1:0] == 2'b00 ? "R8 untagged no pvid" : "R7 discard bypass",
                  48'h0180C2000000, 16'h0800, s[0], s[1], s[2], 7'h70, 3'd1);
        sendCheck("R7 non-trap discard", 48'h0000AA000000, 16'h0800, s[0], s[1], s[2],
                  7'h70, 3'd1);
      end
    end

    // R10 idle gives no valid
    @(negedge clk);
    frmValid = 1'b0;
    @(negedge clk);
    note("R10 idle valid", {31'd0, outValid}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

endmodule